// File: doc/BRIEF.md
# Two-Phase Stepper Excitation Sequencer

This block drives the four phase outputs of a two-phase stepper motor: the two complementary A-winding outputs and the two complementary B-winding outputs. A step clock arrives from a pin, and each qualified edge of that clock moves a two-bit excitation state one position along a four-state full-step pattern. A direction pin chooses whether the state counts up or down. An edge-mode pin chooses the steps: either rising edges only, or both rising and falling edges.

All control pins are treated as asynchronous and pass through two-flop synchronizers into a fast system clock domain. Timing is measured in ticks of a prescaler, and one tick is `CLK_PER_TICK` system cycles. With a 50 MHz system clock the default is one tick per microsecond.

The block also checks the timing of its inputs and records faults in three sticky flags:
- step-clock levels that are too short;
- direction changes too close to a rising step edge;
- step edges that come too soon after the external reset is released.

An output-enable pin turns every phase output off. While it is low the excitation state is kept unchanged, so the motor resumes from the same phase when it returns high.

Top module: `stepper_phase_seq`

## Requirements
- R1: The excitation state, shown on (a, ab, b, bb), follows state 0 = 1010, state 1 = 0110, state 2 = 0101, state 3 = 1001. With dir_i high, each qualified step moves it 0→1→2→3→0.
- R2: With dir_i low, each qualified step moves the state backward: 0→3→2→1→0.
- R3: With edge_mode_i high, only rising step_i edges step and falling edges are ignored. With edge_mode_i low, rising and falling edges each step once.
- R4: While enable_i is low, all four phase outputs are 0.
- R5: Step edges that arrive while enable_i is low do not move the state. When enable_i returns high, the outputs show the state that was held before it went low.
- R6: Asserting rst_n or ext_rst_n_i returns the state to 0 (outputs 1010).
- R7: A stepping edge that comes less than RST_GAP_TICKS ticks after ext_rst_n_i is released is ignored and sets early_err_o. Later edges step normally.
- R8: When step_i changes after a level shorter than MIN_PULSE_TICKS ticks, pulse_err_o is set. If that change is a stepping edge, the step is dropped.
- R9: dir_err_o is set when dir_i changes less than DIR_GUARD_TICKS ticks before or after a rising step_i edge. The step itself is still taken, using the synchronized direction.
- R10: The three error flags are sticky. ext_rst_n_i does not clear them; only rst_n clears them to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system (power-on) reset |
| step_i | input | 1 | Asynchronous step clock pin |
| dir_i | input | 1 | Direction: 1 forward, 0 reverse |
| edge_mode_i | input | 1 | 1 rising edges step, 0 both edges step |
| enable_i | input | 1 | 1 normal, 0 all phase outputs off and state frozen |
| ext_rst_n_i | input | 1 | Active-low external sequence reset pin |
| phase_a_o | output | 1 | A winding drive |
| phase_ab_o | output | 1 | A-bar winding drive |
| phase_b_o | output | 1 | B winding drive |
| phase_bb_o | output | 1 | B-bar winding drive |
| pulse_err_o | output | 1 | Sticky: short step-clock level seen |
| dir_err_o | output | 1 | Sticky: direction changed inside guard window |
| early_err_o | output | 1 | Sticky: stepping edge too soon after external reset |

## Verification
The sequence is driven with long, clean pulses in the forward direction, in the reverse direction, and in both edge modes. Checking the state after the high half and after the low half of each pulse tells rising-only stepping apart from dual-edge stepping. Pulses are also sent while the outputs are disabled, which shows that the phase is frozen rather than merely hidden. The error paths are exercised with deliberately short low levels, with direction flips placed two ticks before and two ticks after a rising edge, and with an edge sent shortly after the external reset is released. These cases separate a dropped step from a taken one, and show which flags survive an external reset and which are cleared only by the system reset.

// File: rtl/stepper_phase_seq.sv
module stepper_phase_seq #(
  parameter int CLK_PER_TICK    = 50,
  parameter int MIN_PULSE_TICKS = 10,
  parameter int DIR_GUARD_TICKS = 7,
  parameter int RST_GAP_TICKS   = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_i,
  input  logic dir_i,
  input  logic edge_mode_i,
  input  logic enable_i,
  input  logic ext_rst_n_i,
  output logic phase_a_o,
  output logic phase_ab_o,
  output logic phase_b_o,
  output logic phase_bb_o,
  output logic pulse_err_o,
  output logic dir_err_o,
  output logic early_err_o
);

  localparam int LIM_AB = (MIN_PULSE_TICKS > DIR_GUARD_TICKS) ? MIN_PULSE_TICKS : DIR_GUARD_TICKS;
  localparam int LIM    = (LIM_AB > RST_GAP_TICKS) ? LIM_AB : RST_GAP_TICKS;
  localparam int CW     = $clog2(LIM + 1);
  localparam int PW     = $clog2(CLK_PER_TICK + 1);
  localparam logic [PW-1:0] P_PRE_LAST = PW'(CLK_PER_TICK - 1);
  localparam logic [CW-1:0] P_MIN = CW'(MIN_PULSE_TICKS);
  localparam logic [CW-1:0] P_GRD = CW'(DIR_GUARD_TICKS);
  localparam logic [CW-1:0] P_GAP = CW'(RST_GAP_TICKS);

  logic [4:0] sync1, sync2;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= {ext_rst_n_i, edge_mode_i, enable_i, dir_i, step_i};
      sync2 <= sync1;
    end

  logic step_s, dir_s, en_s, mode_s, xrst_s;
  assign {xrst_s, mode_s, en_s, dir_s, step_s} = sync2;

  logic step_prev, dir_prev;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      step_prev <= 1'b0;
      dir_prev  <= 1'b0;
    end else begin
      step_prev <= step_s;
      dir_prev  <= dir_s;
    end

  logic step_rise, step_edge, dir_chg, active_edge;
  assign step_rise   = step_s & ~step_prev;
  assign step_edge   = step_s ^ step_prev;
  assign dir_chg     = dir_s ^ dir_prev;
  assign active_edge = mode_s ? step_rise : step_edge;

  logic [PW-1:0] pre;
  logic tick;
  assign tick = (pre == P_PRE_LAST);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    pre <= '0;
    else if (tick) pre <= '0;
    else           pre <= pre + 1'b1;

  logic [CW-1:0] lvl_cnt, dir_age, rise_age, gap_cnt;
  logic width_ok, gap_ok;
  assign width_ok = (lvl_cnt >= P_MIN);
  assign gap_ok   = (gap_cnt >= P_GAP);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lvl_cnt  <= P_MIN;
      dir_age  <= P_GRD;
      rise_age <= P_GRD;
      gap_cnt  <= '0;
    end else begin
      if (step_edge)                     lvl_cnt <= '0;
      else if (tick && lvl_cnt < P_MIN)  lvl_cnt <= lvl_cnt + 1'b1;
      if (dir_chg)                       dir_age <= '0;
      else if (tick && dir_age < P_GRD)  dir_age <= dir_age + 1'b1;
      if (step_rise)                     rise_age <= '0;
      else if (tick && rise_age < P_GRD) rise_age <= rise_age + 1'b1;
      if (!xrst_s)                       gap_cnt <= '0;
      else if (tick && gap_cnt < P_GAP)  gap_cnt <= gap_cnt + 1'b1;
    end

  logic step_go;
  assign step_go = active_edge & width_ok & gap_ok & en_s & xrst_s;

  logic [1:0] phase;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       phase <= 2'd0;
    else if (!xrst_s) phase <= 2'd0;
    else if (step_go) phase <= dir_s ? phase + 2'd1 : phase - 2'd1;

  logic pulse_bad, dir_bad, early_bad;
  assign pulse_bad = xrst_s & step_edge & ~width_ok;
  assign early_bad = xrst_s & active_edge & ~gap_ok;
  assign dir_bad   = xrst_s & ((step_rise & (dir_chg | (dir_age < P_GRD)))
                             | (dir_chg & (rise_age < P_GRD)));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pulse_err_o <= 1'b0;
      dir_err_o   <= 1'b0;
      early_err_o <= 1'b0;
    end else begin
      if (pulse_bad) pulse_err_o <= 1'b1;
      if (dir_bad)   dir_err_o   <= 1'b1;
      if (early_bad) early_err_o <= 1'b1;
    end

  assign phase_a_o  = en_s & (phase == 2'd0 || phase == 2'd3);
  assign phase_ab_o = en_s & (phase == 2'd1 || phase == 2'd2);
  assign phase_b_o  = en_s & (phase == 2'd0 || phase == 2'd1);
  assign phase_bb_o = en_s & (phase == 2'd2 || phase == 2'd3);

  a_r1_single_move: assert property (@(posedge clk) disable iff (!rst_n)
    xrst_s |=> (phase == $past(phase) || phase == $past(phase) + 2'd1 || phase == $past(phase) - 2'd1));
  a_r4_pair_count: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({phase_a_o, phase_ab_o, phase_b_o, phase_bb_o}) == (en_s ? 2 : 0));
  a_r4_pair_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(phase_a_o && phase_ab_o) && !(phase_b_o && phase_bb_o));
  a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_s && xrst_s) |=> $stable(phase));
  a_r6_home: assert property (@(posedge clk) disable iff (!rst_n)
    !xrst_s |=> phase == 2'd0);
  a_r7_early_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (xrst_s && gap_cnt < P_GAP) |=> $stable(phase));
  a_r8_short_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (xrst_s && step_edge && !width_ok) |=> $stable(phase));
  a_r10_pulse_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_err_o |=> pulse_err_o);
  a_r10_dir_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    dir_err_o |=> dir_err_o);
  a_r10_early_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    early_err_o |=> early_err_o);

endmodule

// File: tb/stepper_phase_seq_test.sv
module stepper_phase_seq_test;
  localparam int TICK = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step_i = 1'b0, dir_i = 1'b1, edge_mode_i = 1'b1, enable_i = 1'b1, ext_rst_n_i = 1'b1;
  logic phase_a_o, phase_ab_o, phase_b_o, phase_bb_o;
  logic pulse_err_o, dir_err_o, early_err_o;

  int checks = 0;
  int errors = 0;
  int exp_st = 0;

  always #10 clk = ~clk;

  stepper_phase_seq #(.CLK_PER_TICK(TICK)) uut (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .dir_i(dir_i),
    .edge_mode_i(edge_mode_i), .enable_i(enable_i), .ext_rst_n_i(ext_rst_n_i),
    .phase_a_o(phase_a_o), .phase_ab_o(phase_ab_o), .phase_b_o(phase_b_o),
    .phase_bb_o(phase_bb_o), .pulse_err_o(pulse_err_o), .dir_err_o(dir_err_o),
    .early_err_o(early_err_o));

  function automatic logic [3:0] enc(int s);
    case (s & 3)
      0: return 4'b1010;
      1: return 4'b0110;
      2: return 4'b0101;
      default: return 4'b1001;
    endcase
  endfunction

  task automatic wait_us(int n);
    repeat (n * TICK) @(negedge clk);
  endtask

  task automatic chk4(logic [3:0] exp, string req);
    logic [3:0] got;
    got = {phase_a_o, phase_ab_o, phase_b_o, phase_bb_o};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s phases got=%b exp=%b", req, got, exp);
    end
  endtask

  task automatic chk1(logic got, logic exp, string req, string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got=%b exp=%b", req, what, got, exp);
    end
  endtask

  task automatic pulse(int hi_us, int lo_us, int d_rise, int d_fall, string req);
    step_i = 1'b1;
    wait_us(hi_us);
    exp_st = (exp_st + d_rise) & 3;
    chk4(enc(exp_st), req);
    step_i = 1'b0;
    wait_us(lo_us);
    exp_st = (exp_st + d_fall) & 3;
    chk4(enc(exp_st), req);
  endtask

  task automatic set_dir(logic v);
    dir_i = v;
    wait_us(15);
  endtask

  task automatic sys_reset();
    rst_n = 1'b0;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    exp_st = 0;
    wait_us(20);
  endtask

  task automatic t_reset();
    sys_reset();
    chk4(enc(0), "R6 reset home");
    chk1(pulse_err_o, 1'b0, "R10", "pulse flag after reset");
    chk1(dir_err_o, 1'b0, "R10", "dir flag after reset");
    chk1(early_err_o, 1'b0, "R10", "early flag after reset");
  endtask

  task automatic t_forward();
    for (int i = 0; i < 4; i++) pulse(15, 15, 1, 0, "R1 R3 forward rising-only");
  endtask

  task automatic t_reverse();
    set_dir(1'b0);
    for (int i = 0; i < 3; i++) pulse(15, 15, -1, 0, "R2 reverse");
    set_dir(1'b1);
  endtask

  task automatic t_dual();
    edge_mode_i = 1'b0;
    wait_us(15);
    for (int i = 0; i < 3; i++) pulse(15, 15, 1, 1, "R3 dual edge");
    edge_mode_i = 1'b1;
    wait_us(15);
  endtask

  task automatic t_enable();
    enable_i = 1'b0;
    wait_us(2);
    chk4(4'b0000, "R4 disabled outputs");
    for (int i = 0; i < 2; i++) begin
      step_i = 1'b1; wait_us(15);
      step_i = 1'b0; wait_us(15);
      chk4(4'b0000, "R4 disabled while stepping");
    end
    enable_i = 1'b1;
    wait_us(2);
    chk4(enc(exp_st), "R5 resume held phase");
    pulse(15, 15, 1, 0, "R5 step after resume");
  endtask

  task automatic t_ext_reset();
    chk1(early_err_o, 1'b0, "R7", "early flag before test");
    ext_rst_n_i = 1'b0;
    wait_us(5);
    exp_st = 0;
    chk4(enc(0), "R6 external reset home");
    ext_rst_n_i = 1'b1;
    wait_us(2);
    pulse(15, 15, 0, 0, "R7 early edge ignored");
    chk1(early_err_o, 1'b1, "R7", "early flag");
    pulse(15, 15, 1, 0, "R7 later edge steps");
  endtask

  task automatic t_short();
    chk1(pulse_err_o, 1'b0, "R8", "pulse flag before test");
    step_i = 1'b1; wait_us(15);
    exp_st = (exp_st + 1) & 3;
    chk4(enc(exp_st), "R8 long level steps");
    step_i = 1'b0; wait_us(3);
    step_i = 1'b1; wait_us(15);
    chk4(enc(exp_st), "R8 edge after short low dropped");
    chk1(pulse_err_o, 1'b1, "R8", "pulse flag");
    step_i = 1'b0; wait_us(15);
  endtask

  task automatic t_dir_before();
    chk1(dir_err_o, 1'b0, "R9", "dir flag before test");
    dir_i = 1'b0;
    wait_us(2);
    pulse(15, 15, -1, 0, "R9 step taken in new direction");
    chk1(dir_err_o, 1'b1, "R9", "dir flag setup side");
    set_dir(1'b1);
  endtask

  task automatic t_sticky();
    ext_rst_n_i = 1'b0; wait_us(5);
    ext_rst_n_i = 1'b1; wait_us(20);
    exp_st = 0;
    chk4(enc(0), "R6 external reset home again");
    chk1(pulse_err_o, 1'b1, "R10", "pulse flag kept over ext reset");
    chk1(dir_err_o, 1'b1, "R10", "dir flag kept over ext reset");
    chk1(early_err_o, 1'b1, "R10", "early flag kept over ext reset");
    sys_reset();
    chk1(pulse_err_o, 1'b0, "R10", "pulse flag cleared");
    chk1(dir_err_o, 1'b0, "R10", "dir flag cleared");
    chk1(early_err_o, 1'b0, "R10", "early flag cleared");
  endtask

  task automatic t_dir_after();
    step_i = 1'b1;
    wait_us(2);
    dir_i = 1'b0;
    wait_us(13);
    exp_st = (exp_st + 1) & 3;
    chk4(enc(exp_st), "R9 step uses direction at edge");
    step_i = 1'b0;
    wait_us(15);
    chk1(dir_err_o, 1'b1, "R9", "dir flag hold side");
  endtask

  initial begin
    t_reset();
    t_forward();
    t_reverse();
    t_dual();
    t_enable();
    t_ext_reset();
    t_short();
    t_dir_before();
    t_sticky();
    t_dir_after();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule